// File: doc/BRIEF.md
# PAE Three-Level Page-Table Walker

This block turns a 32-bit virtual address into a physical address by walking three levels of 64-bit translation entries in memory. A small four-slot pointer table is selected from the base register. That slot leads to a directory, and the directory leads to a final table. A directory entry can also end the walk early as a 2 MB page. On the way, the walker combines the user, writable and no-execute bits of each level. It applies the supervisor write-protect rule. It writes the accessed and dirty flags back into the entries.

A request is taken from the requester while the walker is idle. It carries the access kind, the privilege, the base register, the write-protect and no-execute enables, and the address-line mask. These values are captured for the whole walk. Each memory access is a 64-bit read or write, held until the memory acknowledges it. When the walk ends, the walker raises `done` for one cycle. With it comes either the physical address plus read, write and execute permission, or a page fault with its error code.

Top module: `pae_walker`

## Requirements
- R1: The pointer-table slot is read at ((base register with bits 4:0 cleared) + 8 × vaddr[31:30]) AND address mask.
- R2: The directory slot is read at (pointer entry bits 31:12 as a 4 KB-aligned base) + 8 × vaddr[29:21]. The table slot is read at (directory entry bits 31:12 as a base) + 8 × vaddr[20:12]. Both sums are ANDed with the address mask.
- R3: If bit 0 (present) of the entry read at any level is clear, the walk ends in a fault. Error-code bit 0 is 0, and no further memory access is made.
- R4: While the no-execute enable is 0, a directory or table entry with bit 63 set ends the walk in a fault with error-code bit 3 (reserved) set and bit 0 clear.
- R5: The pointer entry places no restriction on access. The effective user bit (bit 2) and writable bit (bit 1) are the AND over the directory and table entries. The page is non-executable if bit 63 is set at either of those levels.
- R6: A present directory entry with bit 7 set is the last level. The physical address is then (entry bits 31:21 AND mask) followed by vaddr[20:0].
- R7: A fetch (access code 2) from a non-executable page is a protection fault. Error-code bit 4 is set only for a fetch while the no-execute enable is 1.
- R8: A user access needs the effective user bit, and a user write also needs the effective writable bit. A supervisor write needs the effective writable bit only when write-protect is enabled. A failed check is a fault with bit 0 set. In every fault, bit 1 equals access-code bit 0 (code 1 means write) and bit 2 equals the user flag.
- R9: A 4 KB-path directory entry with bit 5 (accessed) clear is written back once with bit 5 set, before the table is read. A final entry lacking bit 5, or a write to a final entry lacking bit 6 (dirty), is written back in one 64-bit write with bit 5 set, plus bit 6 when writing. This write happens before `done`.
- R10: A successful walk always grants read. It grants execute exactly when the page is executable. It grants write only if the final entry is dirty after the walk and, for a user access, the effective writable bit is set, or, for a supervisor access, write-protect is off or the effective writable bit is set.
- R11: For a 4 KB page the physical address is (table entry bits 31:12 AND mask) followed by vaddr[11:0]. A fault reports a zero address and no permissions.
- R12: A memory request and its address and direction stay unchanged until acknowledged. `done` lasts one cycle per walk.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Start a walk (taken only while idle) |
| req_vaddr | input | 32 | Virtual address to translate |
| req_acc | input | 2 | Access kind: 0 read, 1 write, 2 fetch |
| req_user | input | 1 | Access made at user privilege |
| cr3_base | input | 32 | Translation base register |
| wp_enable | input | 1 | Supervisor write-protect enable |
| nx_enable | input | 1 | No-execute enable |
| a20_mask | input | 32 | Physical address mask |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | 32 | Entry address |
| mem_wdata | output | 64 | Entry write data |
| mem_ack | input | 1 | Memory acknowledge, read data valid |
| mem_rdata | input | 64 | Entry read data |
| done | output | 1 | Walk result valid for one cycle |
| fault | output | 1 | Walk ended in a page fault |
| err_code | output | 5 | Fault code: 0 prot, 1 write, 2 user, 3 reserved, 4 fetch |
| paddr | output | 32 | Translated physical address |
| perm_r | output | 1 | Read allowed |
| perm_w | output | 1 | Write allowed |
| perm_x | output | 1 | Execute allowed |

## Verification
The bench places its entries so that a walk succeeds only if each level's address is formed correctly, including a base register with stray low bits and an address mask that folds bit 20. A walker that skipped the mask or the bit clearing would read an empty slot and report a non-present fault.

No-execute is tested at both the directory and the table, with the enable off and on. Getting it wrong shows up as a missing reserved fault, a missing fetch flag, or execute granted on a protected page.

Write-protect and the user bit combined across levels are tested from both privilege levels. An AND applied at only one level would grant user access through a supervisor directory. The bench counts write-backs per walk and reads them back from memory. A walker that wrote an already-marked entry, wrote before the table read, or forgot the dirty bit would change that count or the stored entry.

// File: rtl/pae_walk_pkg.sv
`timescale 1ns/1ps
package pae_walk_pkg;
    localparam int VA_W   = 32;
    localparam int PA_W   = 32;
    localparam int ENT_W  = 64;
    localparam int ERR_W  = 5;
    localparam int PG_SH  = 12;
    localparam int BIG_SH = 21;
    localparam int PTR_SH = 30;
    localparam int SLOT_SH = 3;
    localparam int CR3_CLR = 5;

    // entry bit positions
    localparam int B_P  = 0;
    localparam int B_RW = 1;
    localparam int B_US = 2;
    localparam int B_A  = 5;
    localparam int B_D  = 6;
    localparam int B_PS = 7;
    localparam int B_NX = 63;

    localparam logic [1:0] ACC_WR    = 2'd1;
    localparam logic [1:0] ACC_FETCH = 2'd2;

    typedef enum logic [2:0] {
        ST_IDLE, ST_PTR, ST_DIR, ST_DIR_MARK, ST_TBL, ST_FINAL_WB
    } walk_st_e;

    typedef enum logic [1:0] {LV_PTR, LV_DIR, LV_TBL} walk_lvl_e;
endpackage

// File: rtl/pae_entry_addr.sv
`timescale 1ns/1ps
module pae_entry_addr
    import pae_walk_pkg::*;
(
    input  walk_lvl_e             lvl,
    input  logic [PA_W-1:0]       cr3,
    input  logic [VA_W-1:0]       va,
    input  logic [PA_W-1:PG_SH]   ptr_base,
    input  logic [PA_W-1:PG_SH]   dir_base,
    input  logic [PA_W-1:0]       mask,
    output logic [PA_W-1:0]       addr
);
    localparam int IDX_W = BIG_SH - PG_SH;
    logic [PA_W-1:0] raw;
    logic unused_cr3_low;
    assign unused_cr3_low = ^cr3[CR3_CLR-1:0];

    always_comb begin
        unique case (lvl)
            LV_PTR: raw = {cr3[PA_W-1:CR3_CLR], {CR3_CLR{1'b0}}}
                        + PA_W'({va[VA_W-1:PTR_SH], {SLOT_SH{1'b0}}});
            LV_DIR: raw = {ptr_base, {PG_SH{1'b0}}}
                        + PA_W'({va[PTR_SH-1:BIG_SH], {SLOT_SH{1'b0}}});
            LV_TBL: raw = {dir_base, {PG_SH{1'b0}}}
                        + PA_W'({va[PG_SH+IDX_W-1:PG_SH], {SLOT_SH{1'b0}}});
            default: raw = '0;
        endcase
        addr = raw & mask;
    end
endmodule

// File: rtl/pae_perm_eval.sv
`timescale 1ns/1ps
module pae_perm_eval
    import pae_walk_pkg::*;
(
    input  logic [ENT_W-1:0] ent,
    input  logic             up_u,
    input  logic             up_rw,
    input  logic             up_nx,
    input  logic [1:0]       acc,
    input  logic             usr,
    input  logic             wp,
    output logic             prot_fault,
    output logic             wb_need,
    output logic [ENT_W-1:0] wb_ent,
    output logic             can_w,
    output logic             can_x
);
    logic u_c, rw_c, nx_c, is_wr, is_fetch, dirty_new, d_after;

    always_comb begin
        u_c       = up_u  & ent[B_US];
        rw_c      = up_rw & ent[B_RW];
        nx_c      = up_nx | ent[B_NX];
        is_wr     = acc[0];
        is_fetch  = (acc == ACC_FETCH);
        prot_fault = (is_fetch && nx_c)
                   || (usr && (!u_c || (is_wr && !rw_c)))
                   || (!usr && wp && is_wr && !rw_c);
        dirty_new = is_wr && !ent[B_D];
        wb_need   = !ent[B_A] || dirty_new;
        wb_ent    = ent | (ENT_W'(1) << B_A) | (ENT_W'(dirty_new) << B_D);
        d_after   = ent[B_D] | dirty_new;
        can_w     = d_after && (usr ? rw_c : (!wp || rw_c));
        can_x     = !nx_c;
    end
endmodule

// File: rtl/pae_walker.sv
`timescale 1ns/1ps
module pae_walker
    import pae_walk_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid,
    input  logic [VA_W-1:0]      req_vaddr,
    input  logic [1:0]           req_acc,
    input  logic                 req_user,
    input  logic [PA_W-1:0]      cr3_base,
    input  logic                 wp_enable,
    input  logic                 nx_enable,
    input  logic [PA_W-1:0]      a20_mask,
    output logic                 mem_req,
    output logic                 mem_we,
    output logic [PA_W-1:0]      mem_addr,
    output logic [ENT_W-1:0]     mem_wdata,
    input  logic                 mem_ack,
    input  logic [ENT_W-1:0]     mem_rdata,
    output logic                 done,
    output logic                 fault,
    output logic [ERR_W-1:0]     err_code,
    output logic [PA_W-1:0]      paddr,
    output logic                 perm_r,
    output logic                 perm_w,
    output logic                 perm_x
);
    typedef struct packed {
        walk_st_e             st;
        logic [VA_W-1:0]      va;
        logic [1:0]           acc;
        logic                 usr;
        logic                 wp;
        logic                 nxe;
        logic [PA_W-1:0]      cr3;
        logic [PA_W-1:0]      a20;
        logic [PA_W-1:PG_SH]  ptr_base;
        logic [PA_W-1:PG_SH]  dir_base;
        logic                 up_u;
        logic                 up_rw;
        logic                 up_nx;
        logic [ENT_W-1:0]     wb_ent;
        walk_lvl_e            wb_lvl;
        logic                 done;
        logic                 flt;
        logic [ERR_W-1:0]     err;
        logic [PA_W-1:0]      pa;
        logic                 pr;
        logic                 pw;
        logic                 px;
    } walk_t;

    walk_t q, n;

    walk_lvl_e       lvl_sel;
    logic            pv_fault, pv_wb, pv_w, pv_x;
    logic [ENT_W-1:0] pv_ent;
    logic            in_dir, ev_u, ev_rw, ev_nx;
    logic [PA_W-1:0] leaf_base, leaf_off, leaf_pa;
    logic            lf, fl, fp, fr;

    always_comb begin
        unique case (q.st)
            ST_PTR:               lvl_sel = LV_PTR;
            ST_DIR, ST_DIR_MARK:  lvl_sel = LV_DIR;
            ST_TBL:               lvl_sel = LV_TBL;
            ST_FINAL_WB:          lvl_sel = q.wb_lvl;
            default:              lvl_sel = LV_PTR;
        endcase
    end

    pae_entry_addr u_addr (
        .lvl      (lvl_sel),
        .cr3      (q.cr3),
        .va       (q.va),
        .ptr_base (q.ptr_base),
        .dir_base (q.dir_base),
        .mask     (q.a20),
        .addr     (mem_addr)
    );

    assign in_dir = (q.st == ST_DIR);
    assign ev_u   = in_dir ? 1'b1 : q.up_u;
    assign ev_rw  = in_dir ? 1'b1 : q.up_rw;
    assign ev_nx  = in_dir ? 1'b0 : q.up_nx;

    pae_perm_eval u_perm (
        .ent        (mem_rdata),
        .up_u       (ev_u),
        .up_rw      (ev_rw),
        .up_nx      (ev_nx),
        .acc        (q.acc),
        .usr        (q.usr),
        .wp         (q.wp),
        .prot_fault (pv_fault),
        .wb_need    (pv_wb),
        .wb_ent     (pv_ent),
        .can_w      (pv_w),
        .can_x      (pv_x)
    );

    always_comb begin
        if (in_dir) begin
            leaf_base = {mem_rdata[PA_W-1:BIG_SH], {BIG_SH{1'b0}}};
            leaf_off  = PA_W'(q.va[BIG_SH-1:0]);
        end else begin
            leaf_base = {mem_rdata[PA_W-1:PG_SH], {PG_SH{1'b0}}};
            leaf_off  = PA_W'(q.va[PG_SH-1:0]);
        end
        leaf_pa = (leaf_base & q.a20 & ~PA_W'((1 << PG_SH) - 1)) | leaf_off;
    end

    always_comb begin
        n = q;
        n.done = 1'b0;
        lf = 1'b0; fl = 1'b0; fp = 1'b0; fr = 1'b0;
        unique case (q.st)
            ST_IDLE: if (req_valid) begin
                n.st  = ST_PTR;
                n.va  = req_vaddr;
                n.acc = req_acc;
                n.usr = req_user;
                n.wp  = wp_enable;
                n.nxe = nx_enable;
                n.cr3 = cr3_base;
                n.a20 = a20_mask;
                n.flt = 1'b0;
                n.err = '0;
                n.pa  = '0;
                n.pr  = 1'b0;
                n.pw  = 1'b0;
                n.px  = 1'b0;
            end
            ST_PTR: if (mem_ack) begin
                if (!mem_rdata[B_P]) fl = 1'b1;
                else begin
                    n.ptr_base = mem_rdata[PA_W-1:PG_SH];
                    n.st = ST_DIR;
                end
            end
            ST_DIR: if (mem_ack) begin
                if (!mem_rdata[B_P]) fl = 1'b1;
                else if (!q.nxe && mem_rdata[B_NX]) begin
                    fl = 1'b1; fr = 1'b1;
                end else begin
                    n.dir_base = mem_rdata[PA_W-1:PG_SH];
                    n.up_u  = mem_rdata[B_US];
                    n.up_rw = mem_rdata[B_RW];
                    n.up_nx = mem_rdata[B_NX];
                    if (mem_rdata[B_PS]) lf = 1'b1;
                    else if (!mem_rdata[B_A]) begin
                        n.wb_ent = mem_rdata | (ENT_W'(1) << B_A);
                        n.st = ST_DIR_MARK;
                    end else n.st = ST_TBL;
                end
            end
            ST_DIR_MARK: if (mem_ack) n.st = ST_TBL;
            ST_TBL: if (mem_ack) begin
                if (!mem_rdata[B_P]) fl = 1'b1;
                else if (!q.nxe && mem_rdata[B_NX]) begin
                    fl = 1'b1; fr = 1'b1;
                end else lf = 1'b1;
            end
            ST_FINAL_WB: if (mem_ack) begin
                n.st = ST_IDLE;
                n.done = 1'b1;
            end
            default: n.st = ST_IDLE;
        endcase

        if (lf) begin
            if (pv_fault) begin
                fl = 1'b1; fp = 1'b1;
            end else begin
                n.pa = leaf_pa;
                n.pr = 1'b1;
                n.pw = pv_w;
                n.px = pv_x;
                n.wb_lvl = in_dir ? LV_DIR : LV_TBL;
                if (pv_wb) begin
                    n.wb_ent = pv_ent;
                    n.st = ST_FINAL_WB;
                end else begin
                    n.st = ST_IDLE;
                    n.done = 1'b1;
                end
            end
        end

        if (fl) begin
            n.flt = 1'b1;
            n.err = {(q.acc == ACC_FETCH) && q.nxe, fr, q.usr, q.acc[0], fp};
            n.pa  = '0;
            n.pr  = 1'b0;
            n.pw  = 1'b0;
            n.px  = 1'b0;
            n.st  = ST_IDLE;
            n.done = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= n;
    end

    assign mem_req   = (q.st != ST_IDLE);
    assign mem_we    = (q.st == ST_DIR_MARK) || (q.st == ST_FINAL_WB);
    assign mem_wdata = q.wb_ent;
    assign done      = q.done;
    assign fault     = q.flt;
    assign err_code  = q.err;
    assign paddr     = q.pa;
    assign perm_r    = q.pr;
    assign perm_w    = q.pw;
    assign perm_x    = q.px;

    // R12
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));
    // R12
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R11
    fault_noperm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && fault) |-> (!perm_r && !perm_w && !perm_x && paddr == '0));
    // R7
    fetch_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && fault && err_code[4]) |-> (q.acc == ACC_FETCH && q.nxe));
    // R9
    wb_marked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |-> mem_wdata[B_A]);
    // R10
    write_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !fault && q.acc == ACC_WR) |-> (perm_w && perm_r));
endmodule

// File: tb/pae_walker_test.sv
`timescale 1ns/1ps
module pae_walker_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [31:0] req_vaddr = '0;
    logic [1:0]  req_acc = '0;
    logic        req_user = 1'b0;
    logic [31:0] cr3_base = 32'h0000_101F;
    logic        wp_enable = 1'b0;
    logic        nx_enable = 1'b0;
    logic [31:0] a20_mask = 32'hFFFF_FFFF;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr;
    logic [63:0] mem_wdata;
    logic        mem_ack = 1'b0;
    logic [63:0] mem_rdata = '0;
    logic        done, fault;
    logic [4:0]  err_code;
    logic [31:0] paddr;
    logic        perm_r, perm_w, perm_x;

    always #2.5 clk = ~clk;

    pae_walker uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_vaddr(req_vaddr),
        .req_acc(req_acc), .req_user(req_user), .cr3_base(cr3_base),
        .wp_enable(wp_enable), .nx_enable(nx_enable), .a20_mask(a20_mask),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .done(done), .fault(fault), .err_code(err_code), .paddr(paddr),
        .perm_r(perm_r), .perm_w(perm_w), .perm_x(perm_x)
    );

    logic [63:0] mem [logic [31:0]];
    int wr_cnt = 0;

    always @(posedge clk) begin
        if (mem_req && !mem_ack) begin
            mem_ack <= 1'b1;
            if (mem_we) begin
                mem[mem_addr] = mem_wdata;
                wr_cnt <= wr_cnt + 1;
            end else begin
                mem_rdata <= mem.exists(mem_addr) ? mem[mem_addr] : 64'h0;
            end
        end else begin
            mem_ack <= 1'b0;
        end
    end

    typedef struct {
        logic        flt;
        logic [4:0]  err;
        logic [31:0] pa;
        logic        w;
        logic        x;
        int          wr0;
        int          wrs;
        string       tag;
    } item_t;

    item_t sb[$];
    int n_chk = 0, n_bad = 0, issued = 0, seen = 0;

    task automatic chk(input logic ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (done) begin
            if (sb.size() == 0) begin
                chk(1'b0, "R12 unexpected done", 64'(done), 64'h0);
            end else begin
                item_t it;
                it = sb.pop_front();
                chk(fault === it.flt, {it.tag, " fault"}, 64'(fault), 64'(it.flt));
                chk(err_code === it.err, {it.tag, " err_code"}, 64'(err_code), 64'(it.err));
                chk(paddr === it.pa, {it.tag, " paddr"}, 64'(paddr), 64'(it.pa));
                chk(perm_r === !it.flt, {it.tag, " perm_r"}, 64'(perm_r), 64'(!it.flt));
                chk(perm_w === it.w, {it.tag, " perm_w"}, 64'(perm_w), 64'(it.w));
                chk(perm_x === it.x, {it.tag, " perm_x"}, 64'(perm_x), 64'(it.x));
                chk((wr_cnt - it.wr0) == it.wrs, {it.tag, " R9 write count"},
                    64'(wr_cnt - it.wr0), 64'(it.wrs));
            end
            seen++;
        end
    end

    task automatic walk(input logic [31:0] va, input logic [1:0] acc, input logic usr,
                        input logic wp, input logic nxe, input logic [31:0] msk,
                        input logic flt, input logic [4:0] err, input logic [31:0] pa,
                        input logic w, input logic x, input int wrs, input string tag);
        item_t it;
        @(negedge clk);
        req_vaddr = va; req_acc = acc; req_user = usr;
        wp_enable = wp; nx_enable = nxe; a20_mask = msk;
        it.flt = flt; it.err = err; it.pa = pa; it.w = w; it.x = x;
        it.wr0 = wr_cnt; it.wrs = wrs; it.tag = tag;
        sb.push_back(it);
        issued++;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        while (seen < issued) @(negedge clk);
    endtask

    localparam logic [31:0] ALL = 32'hFFFF_FFFF;

    initial begin
        mem[32'h1008] = 64'h0000_0000_0000_2001;
        mem[32'h1010] = 64'h0000_0000_0010_2001;
        mem[32'h2018] = 64'h0000_0000_0000_3007;
        mem[32'h2020] = 64'h0000_0000_00A0_00E7;
        mem[32'h2028] = 64'h0000_0000_00C0_0087;
        mem[32'h2030] = 64'h0000_0000_0000_4023;
        mem[32'h2038] = 64'h8000_0000_0000_4023;
        mem[32'h3010] = 64'h0000_0000_0015_5067;
        mem[32'h3018] = 64'h0000_0000_0005_5067;
        mem[32'h3020] = 64'h0000_0000_0006_6003;
        mem[32'h3028] = 64'h8000_0000_0007_7067;
        mem[32'h3030] = 64'h0000_0000_0008_8065;
        mem[32'h4038] = 64'h0000_0000_0009_9067;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(done === 1'b0, "R12 reset done", 64'(done), 64'h0);
        chk(mem_req === 1'b0, "R12 reset mem_req", 64'(mem_req), 64'h0);

        // R1 R2 R9: user read, directory marked accessed before table read
        walk(32'h4060_3ABC, 2'd0, 1, 0, 1, ALL, 0, 5'h00, 32'h0005_5ABC, 1, 1, 1, "R1 R2 R9 R11 basic");
        chk(mem[32'h2018] === 64'h3027, "R9 dir accessed", mem[32'h2018], 64'h3027);
        walk(32'h4060_3ABC, 2'd0, 1, 0, 1, ALL, 0, 5'h00, 32'h0005_5ABC, 1, 1, 0, "R9 no rewrite");
        // R9 R10: supervisor write to clean page sets A and D
        walk(32'h4060_4123, 2'd1, 0, 1, 1, ALL, 0, 5'h00, 32'h0006_6123, 1, 1, 1, "R9 R10 dirty");
        chk(mem[32'h3020] === 64'h66063, "R9 final A D", mem[32'h3020], 64'h66063);
        // R8: user read on supervisor page
        walk(32'h4060_4123, 2'd0, 1, 0, 1, ALL, 1, 5'h05, 32'h0, 0, 0, 0, "R8 user denied");
        // R7: fetch flag depends on nx enable
        walk(32'h4060_4123, 2'd2, 1, 0, 0, ALL, 1, 5'h05, 32'h0, 0, 0, 0, "R7 fetch nxe0");
        walk(32'h4060_4123, 2'd2, 1, 0, 1, ALL, 1, 5'h15, 32'h0, 0, 0, 0, "R7 fetch nxe1");
        // R3: non-present pointer, table
        walk(32'hC000_0000, 2'd1, 1, 0, 1, ALL, 1, 5'h06, 32'h0, 0, 0, 0, "R3 ptr absent");
        walk(32'h4060_7000, 2'd0, 0, 0, 1, ALL, 1, 5'h00, 32'h0, 0, 0, 0, "R3 tbl absent");
        // R4 R5 R7: no-execute at table level
        walk(32'h4060_5000, 2'd0, 0, 0, 0, ALL, 1, 5'h08, 32'h0, 0, 0, 0, "R4 tbl reserved");
        walk(32'h4060_5000, 2'd2, 0, 0, 1, ALL, 1, 5'h11, 32'h0, 0, 0, 0, "R7 tbl nx fetch");
        walk(32'h4060_5000, 2'd0, 0, 0, 1, ALL, 0, 5'h00, 32'h0007_7000, 1, 0, 0, "R10 nx read");
        // R6: 2 MB pages
        walk(32'h4080_1234, 2'd0, 1, 0, 1, ALL, 0, 5'h00, 32'h00A0_1234, 1, 1, 0, "R6 big read");
        walk(32'h40A0_0010, 2'd1, 1, 0, 1, ALL, 0, 5'h00, 32'h00C0_0010, 1, 1, 1, "R6 R9 big write");
        chk(mem[32'h2028] === 64'hC000E7, "R6 R9 big marked", mem[32'h2028], 64'hC000E7);
        // R8 R10: write protect on a read-only page
        walk(32'h4060_6000, 2'd1, 0, 0, 1, ALL, 0, 5'h00, 32'h0008_8000, 1, 1, 0, "R8 wp off");
        walk(32'h4060_6000, 2'd1, 0, 1, 1, ALL, 1, 5'h03, 32'h0, 0, 0, 0, "R8 wp on");
        walk(32'h4060_6000, 2'd0, 1, 0, 1, ALL, 0, 5'h00, 32'h0008_8000, 0, 1, 0, "R10 user ro");
        // R5: user bit ANDed with directory
        walk(32'h40C0_7000, 2'd0, 1, 0, 1, ALL, 1, 5'h05, 32'h0, 0, 0, 0, "R5 dir user");
        walk(32'h40C0_7000, 2'd0, 0, 0, 1, ALL, 0, 5'h00, 32'h0009_9000, 1, 1, 0, "R5 super ok");
        // R4 R5: no-execute at directory level
        walk(32'h40E0_7000, 2'd0, 0, 0, 0, ALL, 1, 5'h08, 32'h0, 0, 0, 0, "R4 dir reserved");
        walk(32'h40E0_7000, 2'd2, 0, 0, 1, ALL, 1, 5'h11, 32'h0, 0, 0, 0, "R5 dir nx fetch");
        walk(32'h40E0_7000, 2'd0, 0, 0, 1, ALL, 0, 5'h00, 32'h0009_9000, 1, 0, 0, "R5 dir nx read");
        // R11 R2: address mask folds bit 20
        walk(32'h8060_3ABC, 2'd0, 0, 0, 1, 32'hFFEF_FFFF, 0, 5'h00, 32'h0005_5ABC, 1, 1, 0, "R2 R11 mask entry");
        walk(32'h8060_2000, 2'd0, 0, 0, 1, 32'hFFEF_FFFF, 0, 5'h00, 32'h0005_5000, 1, 1, 0, "R11 mask paddr");
        walk(32'h8060_2000, 2'd0, 0, 0, 1, ALL, 1, 5'h00, 32'h0, 0, 0, 0, "R2 R3 unmasked");

        repeat (5) @(negedge clk);
        chk(sb.size() == 0, "R12 pending results", 64'(sb.size()), 64'h0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL R12 watchdog expired actual=%0d expected=%0d", seen, issued);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule